// File: doc/BRIEF.md
# Seven-Channel DMA Register Bank

This block holds the software-visible state of a seven-channel DMA controller and decides, each cycle, which channels are allowed to move data. A register bus writes and reads 32-bit words. Each channel owns three words: a start address, a length descriptor and a control word. One shared word at the end of the bank carries a per-channel priority and a per-channel master enable.

From this state the bank drives one go line per channel to the data movers. It also gives the mover the transfer direction, a signed address step, a masked word address and the total word count decoded from the length descriptor. A mover ends a transfer with a one-cycle done pulse, and that pulse drops the channel's busy bit. Arbitration between channels whose go lines are high, and the movers themselves, sit outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every channel word reads 0, the shared word reads 0x07654321, every go line is low, every address output is 0 and every step output is +4.
- R2: Address bits 7..4 select channel 0..6, and bits 3..2 select the start address (0), the length descriptor (1) or the control word (2). Byte address 0x70 is the shared word. Reads of any other address return 0, and writes to them change no register.
- R3: The start address keeps only bits 23..0 of a write. The channel's address output equals the stored value ANDed with 0x001FFFFC.
- R4: A control-word write stores the written value ANDed with 0x71770703. A length-descriptor write stores all 32 bits.
- R5: Control bit 24 is busy and bit 28 is trigger. Bits 10..9 hold the mode: 0 single-shot, 1 paced, 2 list, 3 spare. A channel's go is high exactly when its master enable and busy are both set, and also trigger (mode 0) or that channel's request input (modes 1 to 3).
- R6: In mode 0 the trigger bit clears at the first clock edge where go is high, so go stays high for one cycle. A control write in that same cycle takes precedence.
- R7: A done pulse clears the channel's busy bit at the next edge, even when a control write to that channel lands in the same cycle, so go is low in the following cycle.
- R8: In mode 0 the word-count output is bits 15..0 of the length descriptor, with 0 decoded as 65536.
- R9: In mode 1 the word-count output is the block size (bits 15..0) times the block count (bits 31..16), each 0 decoded as 65536. In modes 2 and 3 it is 0.
- R10: The direction output is control bit 0 (1 means memory to device). The step output is 8-bit two's complement +4, or -4 when control bit 1 is set.
- R11: Channel n's master enable is bit 4n+3 of the shared word. Its priority (bits 4n+2..4n) is only stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWr | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| chanReq | input | 7 | Per-channel data request from devices |
| chanDone | input | 7 | Per-channel end-of-transfer pulse from movers |
| chanGo | output | 7 | Per-channel transfer permission |
| chanToDev | output | 7 | Per-channel direction, 1 = memory to device |
| chanStep | output | 56 | Per-channel 8-bit signed address step |
| chanAddr | output | 224 | Per-channel 32-bit masked word address |
| chanWords | output | 231 | Per-channel 33-bit decoded word count |

## Verification
A wrong stored bit shows up at the ports in the next cycle. It either appears in the readback word or moves a go, step, address or count output, since all of these are combinational views of the registers. A stuck trigger holds go high past its single cycle, and a missed done pulse leaves go high after the mover has finished. The bench therefore samples both the cycle where the state is written and the cycle after it. A wrong zero decode or product width shows up directly as the word count for the extreme descriptor values.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NCH        = 7;
  localparam int CH_W       = $clog2(NCH);
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int BASE_W     = 24;
  localparam int CNT_W      = 16;
  localparam int WORDS_W    = 2 * CNT_W + 1;
  localparam int STEP_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int NIB_W      = 4;
  localparam int PRIO_ADDR  = NCH * 16;

  localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h7177_0703;
  localparam logic [DATA_W-1:0] PRIO_INIT  = 32'h0765_4321;
  localparam logic [DATA_W-1:0] ADDR_EMASK = 32'h001F_FFFC;

  localparam int CB_DIR  = 0;
  localparam int CB_REV  = 1;
  localparam int CB_MODE = 9;
  localparam int CB_BUSY = 24;
  localparam int CB_TRIG = 28;

  typedef enum logic [1:0] {SM_SINGLE, SM_PACED, SM_LIST, SM_SPARE} syncMode_t;
  typedef enum logic [2:0] {RD_NONE, RD_BASE, RD_BLK, RD_CTRL, RD_PRIO} rdKind_t;

  typedef struct packed {
    logic [NCH-1:0] wrBase;
    logic [NCH-1:0] wrBlk;
    logic [NCH-1:0] wrCtrl;
    logic           wrPrio;
    rdKind_t        rdKind;
    logic [CH_W-1:0] rdChan;
  } regStrobe_t;
endpackage

// File: rtl/dma_regs_decode.sv
module dma_regs_decode
  import dma_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output regStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 4;
  localparam logic [ADDR_W-3:0] PRIO_WORD = (ADDR_W-2)'(PRIO_ADDR / WORD_BYTES);

  logic [IDX_W-1:0] chanIdx;
  logic [1:0]       sub;
  logic             inBank;

  always_comb begin
    chanIdx = busAddr[ADDR_W-1:4];
    sub     = busAddr[3:2];
    inBank  = chanIdx < IDX_W'(NCH);
    strb    = '0;
    strb.rdChan = chanIdx[CH_W-1:0];
    if (inBank) begin
      case (sub)
        2'd0:    strb.rdKind = RD_BASE;
        2'd1:    strb.rdKind = RD_BLK;
        2'd2:    strb.rdKind = RD_CTRL;
        default: strb.rdKind = RD_NONE;
      endcase
    end else if (busAddr[ADDR_W-1:2] == PRIO_WORD) begin
      strb.rdKind = RD_PRIO;
    end
    for (int n = 0; n < NCH; n++) begin
      strb.wrBase[n] = busWr && inBank && (chanIdx == IDX_W'(n)) && (strb.rdKind == RD_BASE);
      strb.wrBlk[n]  = busWr && inBank && (chanIdx == IDX_W'(n)) && (strb.rdKind == RD_BLK);
      strb.wrCtrl[n] = busWr && inBank && (chanIdx == IDX_W'(n)) && (strb.rdKind == RD_CTRL);
    end
    strb.wrPrio = busWr && (strb.rdKind == RD_PRIO);
  end
endmodule

// File: rtl/dma_regs_dp.sv
module dma_regs_dp
  import dma_regs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strb,
  input  logic [DATA_W-1:0]       busWdata,
  input  logic [NCH-1:0]          chanReq,
  input  logic [NCH-1:0]          chanDone,
  output logic [DATA_W-1:0]       busRdata,
  output logic [NCH-1:0]          chanGo,
  output logic [NCH-1:0]          chanToDev,
  output logic [NCH*STEP_W-1:0]   chanStep,
  output logic [NCH*DATA_W-1:0]   chanAddr,
  output logic [NCH*WORDS_W-1:0]  chanWords
);
  localparam logic [STEP_W-1:0] STEP_FWD = STEP_W'(WORD_BYTES);
  localparam logic [STEP_W-1:0] STEP_BWD = ~STEP_W'(WORD_BYTES) + 1'b1;
  localparam logic [CNT_W:0]    CNT_MAX  = {1'b1, {CNT_W{1'b0}}};

  logic [DATA_W-1:0] prioQ;
  logic [BASE_W-1:0] baseArr [NCH];
  logic [DATA_W-1:0] blkArr  [NCH];
  logic [DATA_W-1:0] ctrlArr [NCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            prioQ <= PRIO_INIT;
    else if (strb.wrPrio) prioQ <= busWdata;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [BASE_W-1:0] baseQ;
    logic [DATA_W-1:0] blkQ;
    logic [DATA_W-1:0] ctrlQ;
    logic [DATA_W-1:0] ctrlNext;
    syncMode_t         mode;
    logic              startSingle;
    logic [CNT_W:0]    sizeDec;
    logic [CNT_W:0]    countDec;
    logic [2*CNT_W+1:0] prod;

    assign mode = syncMode_t'(ctrlQ[CB_MODE+1:CB_MODE]);
    assign chanGo[n] = prioQ[NIB_W*n+3] & ctrlQ[CB_BUSY] &
                       ((mode == SM_SINGLE) ? ctrlQ[CB_TRIG] : chanReq[n]);
    assign startSingle = chanGo[n] && (mode == SM_SINGLE);

    always_comb begin
      ctrlNext = ctrlQ;
      if (strb.wrCtrl[n])   ctrlNext = busWdata & CTRL_WMASK;
      else if (startSingle) ctrlNext[CB_TRIG] = 1'b0;
      if (chanDone[n])      ctrlNext[CB_BUSY] = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        blkQ  <= '0;
        ctrlQ <= '0;
      end else begin
        if (strb.wrBase[n]) baseQ <= busWdata[BASE_W-1:0];
        if (strb.wrBlk[n])  blkQ  <= busWdata;
        ctrlQ <= ctrlNext;
      end
    end

    assign sizeDec  = (blkQ[CNT_W-1:0] == '0) ? CNT_MAX : {1'b0, blkQ[CNT_W-1:0]};
    assign countDec = (blkQ[2*CNT_W-1:CNT_W] == '0) ? CNT_MAX : {1'b0, blkQ[2*CNT_W-1:CNT_W]};
    assign prod     = (2*CNT_W+2)'(sizeDec) * (2*CNT_W+2)'(countDec);

    always_comb begin
      case (mode)
        SM_SINGLE: chanWords[n*WORDS_W +: WORDS_W] = WORDS_W'(sizeDec);
        SM_PACED:  chanWords[n*WORDS_W +: WORDS_W] = prod[WORDS_W-1:0];
        default:   chanWords[n*WORDS_W +: WORDS_W] = '0;
      endcase
    end

    assign chanToDev[n] = ctrlQ[CB_DIR];
    assign chanStep[n*STEP_W +: STEP_W] = ctrlQ[CB_REV] ? STEP_BWD : STEP_FWD;
    assign chanAddr[n*DATA_W +: DATA_W] = DATA_W'(baseQ) & ADDR_EMASK;

    assign baseArr[n] = baseQ;
    assign blkArr[n]  = blkQ;
    assign ctrlArr[n] = ctrlQ;
  end

  always_comb begin
    case (strb.rdKind)
      RD_BASE: busRdata = DATA_W'(baseArr[strb.rdChan]);
      RD_BLK:  busRdata = blkArr[strb.rdChan];
      RD_CTRL: busRdata = ctrlArr[strb.rdChan];
      RD_PRIO: busRdata = prioQ;
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWr,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  input  logic [NCH-1:0]          chanReq,
  input  logic [NCH-1:0]          chanDone,
  output logic [NCH-1:0]          chanGo,
  output logic [NCH-1:0]          chanToDev,
  output logic [NCH*STEP_W-1:0]   chanStep,
  output logic [NCH*DATA_W-1:0]   chanAddr,
  output logic [NCH*WORDS_W-1:0]  chanWords
);
  regStrobe_t strb;

  dma_regs_decode u_decode (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strb    (strb)
  );

  dma_regs_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .chanReq   (chanReq),
    .chanDone  (chanDone),
    .busRdata  (busRdata),
    .chanGo    (chanGo),
    .chanToDev (chanToDev),
    .chanStep  (chanStep),
    .chanAddr  (chanAddr),
    .chanWords (chanWords)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWr,
  input logic [DATA_W-1:0]       busWdata,
  input logic [NCH-1:0]          chanReq,
  input logic [NCH-1:0]          chanDone,
  input logic [NCH-1:0]          chanGo,
  input logic [NCH*STEP_W-1:0]   chanStep,
  input logic [NCH*DATA_W-1:0]   chanAddr
);
  localparam logic [ADDR_W-3:0] PRIO_WORD = (ADDR_W-2)'(PRIO_ADDR / WORD_BYTES);

  // R1
  reset_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chanGo == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R7
    done_drops_go_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanDone[n] |=> !chanGo[n]);
    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanGo[n] && !chanReq[n] && !busWr) |=> !chanGo[n]);
    // R11
    enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr[ADDR_W-1:2] == PRIO_WORD && !busWdata[NIB_W*n+3]) |=> !chanGo[n]);
    // R10
    step_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanStep[n*STEP_W +: STEP_W] == 8'h04) || (chanStep[n*STEP_W +: STEP_W] == 8'hFC));
    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanAddr[n*DATA_W +: DATA_W] & ~ADDR_EMASK) == '0);
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busWdata (busWdata),
  .chanReq  (chanReq),
  .chanDone (chanDone),
  .chanGo   (chanGo),
  .chanStep (chanStep),
  .chanAddr (chanAddr)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  import dma_regs_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [ADDR_W-1:0]      busAddr = '0;
  logic                   busWr = 1'b0;
  logic [DATA_W-1:0]      busWdata = '0;
  logic [DATA_W-1:0]      busRdata;
  logic [NCH-1:0]         chanReq = '0;
  logic [NCH-1:0]         chanDone = '0;
  logic [NCH-1:0]         chanGo;
  logic [NCH-1:0]         chanToDev;
  logic [NCH*STEP_W-1:0]  chanStep;
  logic [NCH*DATA_W-1:0]  chanAddr;
  logic [NCH*WORDS_W-1:0] chanWords;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .chanReq(chanReq), .chanDone(chanDone), .chanGo(chanGo),
    .chanToDev(chanToDev), .chanStep(chanStep), .chanAddr(chanAddr), .chanWords(chanWords)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [7:0] cAddr(int ch, int sel);
    return 8'(ch * 16 + sel * 4);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++) begin
      for (int s = 0; s < 3; s++) begin
        rd(cAddr(ch, s), d);
        check("R1", d, 0, "channel word after reset");
      end
      check("R1", chanStep[ch*8 +: 8], 8'h04, "step after reset");
      check("R1", chanAddr[ch*32 +: 32], 0, "address after reset");
    end
    rd(8'h70, d);
    check("R1", d, 32'h0765_4321, "shared word after reset");
    check("R1", chanGo, 0, "go after reset");

    // R2 R3 R4 R10 map, masks, direction, step
    for (int ch = 0; ch < NCH; ch++) begin
      logic [31:0] bv;
      bv = 32'hFFFF_FFFF ^ (32'h0101_0110 * (ch + 1));
      wr(cAddr(ch, 0), bv);
      wr(cAddr(ch, 1), 32'hA5A5_0000 | ch);
      wr(cAddr(ch, 2), 32'hFFFF_FFFF);
      rd(cAddr(ch, 0), d);
      check("R3", d, {8'h00, bv[23:0]}, "start address keeps 24 bits");
      check("R3", chanAddr[ch*32 +: 32], bv & 32'h001F_FFFC, "masked address");
      rd(cAddr(ch, 1), d);
      check("R4", d, 32'hA5A5_0000 | ch, "length descriptor full width");
      rd(cAddr(ch, 2), d);
      check("R4", d, 32'h7177_0703, "control write mask");
      check("R10", chanToDev[ch], 1, "direction set");
      check("R10", chanStep[ch*8 +: 8], 8'hFC, "reverse step");
      check("R2", chanGo, 0, "no go with enables off");
      wr(cAddr(ch, 2), 32'h0000_0001);
      check("R10", chanStep[ch*8 +: 8], 8'h04, "forward step");
      check("R10", chanToDev[ch], 1, "direction bit 0");
      wr(cAddr(ch, 2), 32'h0);
      check("R10", chanToDev[ch], 0, "direction cleared");
    end

    // R2 unmapped addresses
    wr(8'h00, 32'h0012_3450);
    foreach (d[i]) ;
    begin
      logic [7:0] holes [4];
      holes[0] = 8'h0C; holes[1] = 8'h74; holes[2] = 8'h7C; holes[3] = 8'hF0;
      for (int h = 0; h < 4; h++) begin
        wr(holes[h], 32'hFFFF_FFFF);
        rd(holes[h], d);
        check("R2", d, 0, "unmapped read");
      end
    end
    rd(8'h00, d);
    check("R2", d, 32'h0012_3450, "base untouched by unmapped writes");
    rd(8'h70, d);
    check("R2", d, 32'h0765_4321, "shared word untouched by unmapped writes");
    rd(8'h08, d);
    check("R2", d, 0, "control untouched by unmapped writes");

    // R5 R6 R11 eligibility sweep
    for (int ch = 0; ch < NCH; ch++) begin
      for (int c = 0; c < 64; c++) begin
        logic en, busy, trig, req, exp;
        logic [1:0] mode;
        logic [31:0] cw;
        en = c[0]; busy = c[1]; trig = c[2]; req = c[3]; mode = 2'(c >> 4);
        chanReq = NCH'(req) << ch;
        wr(8'h70, 32'h0765_4321 | (32'(en) << (4*ch+3)));
        cw = (32'(mode) << 9) | (32'(busy) << 24) | (32'(trig) << 28);
        wr(cAddr(ch, 2), cw);
        exp = en & busy & ((mode == 2'd0) ? trig : req);
        check("R5", chanGo, NCH'(exp) << ch, "go rule");
        @(negedge clk);
        if (mode == 2'd0 && exp) begin
          check("R6", chanGo, 0, "single-shot go lasts one cycle");
          rd(cAddr(ch, 2), d);
          check("R6", d, cw & ~32'h1000_0000, "trigger self-cleared");
        end else begin
          check("R11", chanGo, NCH'(exp) << ch, "go steady");
        end
        chanReq = '0;
        wr(cAddr(ch, 2), 32'h0);
      end
    end

    // R7 done pulse
    wr(8'h70, 32'h0FED_CBA9);
    for (int ch = 0; ch < NCH; ch++) begin
      chanReq = NCH'(1) << ch;
      wr(cAddr(ch, 2), 32'h0100_0200);
      check("R7", chanGo, NCH'(1) << ch, "go before done");
      chanDone = NCH'(1) << ch;
      @(negedge clk);
      chanDone = '0;
      check("R7", chanGo, 0, "go after done");
      rd(cAddr(ch, 2), d);
      check("R7", d, 32'h0000_0200, "busy cleared");
      @(negedge clk);
      busAddr = cAddr(ch, 2); busWdata = 32'h0100_0200; busWr = 1'b1;
      chanDone = NCH'(1) << ch;
      @(negedge clk);
      busWr = 1'b0; chanDone = '0;
      check("R7", chanGo, 0, "done beats same-cycle write");
      rd(cAddr(ch, 2), d);
      check("R7", d, 32'h0000_0200, "busy cleared over write");
      chanReq = '0;
    end

    // R8 R9 word count decode
    for (int ch = 0; ch < NCH; ch++) begin
      logic [15:0] mv [4];
      logic [15:0] bs [5];
      logic [15:0] bc [5];
      mv[0] = 16'h0; mv[1] = 16'h1; mv[2] = 16'h1234; mv[3] = 16'hFFFF;
      bs[0] = 0; bc[0] = 0; bs[1] = 0; bc[1] = 1; bs[2] = 3; bc[2] = 5;
      bs[3] = 16'hFFFF; bc[3] = 2; bs[4] = 16'h10; bc[4] = 0;
      wr(cAddr(ch, 2), 32'h0);
      for (int i = 0; i < 4; i++) begin
        wr(cAddr(ch, 1), {16'hBEEF, mv[i]});
        check("R8", chanWords[ch*33 +: 33], (mv[i] == 0) ? 65536 : 64'(mv[i]), "single-shot count");
      end
      wr(cAddr(ch, 2), 32'h0000_0200);
      for (int i = 0; i < 5; i++) begin
        logic [63:0] e;
        wr(cAddr(ch, 1), {bc[i], bs[i]});
        e = ((bs[i] == 0) ? 64'd65536 : 64'(bs[i])) * ((bc[i] == 0) ? 64'd65536 : 64'(bc[i]));
        check("R9", chanWords[ch*33 +: 33], e, "paced count");
      end
      wr(cAddr(ch, 2), 32'h0000_0400);
      check("R9", chanWords[ch*33 +: 33], 0, "list mode count");
      wr(cAddr(ch, 2), 32'h0000_0600);
      check("R9", chanWords[ch*33 +: 33], 0, "spare mode count");
      wr(cAddr(ch, 2), 32'h0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule